// File: doc/BRIEF.md
# Compare Match Output Unit

This unit owns the single output-compare state bit of a timer channel and decides what the channel's port pin drives. Each clock it takes three events from the timer: a compare match, the counter reaching bottom, and a force strobe from software. It also takes a waveform-mode select and a 2-bit compare-output field. From these it sets, clears or toggles the state bit. The counter, the compare register and interrupt logic sit outside this unit.

The pin value is either the state bit or the ordinary port data bit. The state bit is used whenever the compare-output field asks for an override. The pin's output enable always follows the port direction bit and is never taken over. Because of this, firmware can preset the state bit with the force strobe while the pin is still an input, and then turn the pin into an output. The state bit keeps its value across mode changes. Writes to the compare-output field are not buffered, so a new value applies to the very next event.

Top module: `occ_unit`

## Requirements
- R1: After reset the state output `oc_state_o` is 0. At all times `pin_oe_o` equals `port_dir_i`.
- R2: With `com_i` = 0, no match, bottom or force event changes the state, and `pin_out_o` equals `port_data_i`.
- R3: When the override is active, `pin_out_o` equals the state bit in the same cycle. The override is active when `com_i` is nonzero, except for the reserved case in R7. Direction is never affected by the override.
- R4: In non-PWM mode (`pwm_mode_i` = 0), `com_i` = 1 inverts the state on the clock edge that samples a compare match.
- R5: In non-PWM mode, `com_i` = 2 clears the state on a match and `com_i` = 3 sets it. The bottom event has no effect in this mode.
- R6: In fast PWM mode (`pwm_mode_i` = 1), `com_i` = 2 clears the state on a match and sets it at bottom. `com_i` = 3 sets it on a match and clears it at bottom. When match and bottom arrive in the same cycle, the match action wins.
- R7: In fast PWM mode, `com_i` = 1 is reserved. It causes no state change and no override, so `pin_out_o` equals `port_data_i`.
- R8: In non-PWM mode, `force_i` applies the configured action on the next edge without a match. A force that coincides with a match applies the action only once, so a toggle inverts the state once.
- R9: In fast PWM mode, `force_i` has no effect on the state.
- R10: The state bit keeps its value when `pwm_mode_i` changes and no event occurs.
- R11: A new `com_i` value takes effect in the same cycle it is presented. A match sampled together with a new field value uses the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmp_match_i | input | 1 | Compare match event from the timer |
| cnt_bottom_i | input | 1 | Counter-at-bottom event from the timer |
| pwm_mode_i | input | 1 | 0 = non-PWM counting, 1 = fast PWM |
| com_i | input | 2 | Compare-output action field |
| force_i | input | 1 | Force-compare strobe |
| port_data_i | input | 1 | Ordinary port data bit |
| port_dir_i | input | 1 | Port direction bit, 1 = output |
| pin_out_o | output | 1 | Value presented to the pin driver |
| pin_oe_o | output | 1 | Pin output enable |
| oc_state_o | output | 1 | Output-compare state bit |

## Verification
A corrupted state bit shows up on `pin_out_o` one clock after the event that caused it, provided the override is active. The bad value then stays until the next action event. When `com_i` is 0 or reserved, the error is hidden at the pin and shows only on `oc_state_o`. For that reason the sweep checks both outputs one cycle after every combination of mode, field, match, bottom and force, starting from each initial state. A fault in the pin multiplexer is visible in the same cycle, without waiting for a clock edge.

// File: rtl/occ_pkg.sv
package occ_pkg;

  localparam int COM_W = 2;

  typedef enum logic [COM_W-1:0] {
    COM_OFF    = 2'd0,
    COM_TOGGLE = 2'd1,
    COM_CLEAR  = 2'd2,
    COM_SET    = 2'd3
  } com_e;

  typedef struct packed {
    logic set;
    logic clr;
    logic tgl;
  } occ_act_t;

  // Action decode: at most one of set/clr/tgl is raised.
  function automatic occ_act_t occ_decode(input logic pwm, input logic [COM_W-1:0] com,
                                          input logic match, input logic bottom,
                                          input logic frc);
    occ_act_t a;
    logic ev;
    a  = '0;
    ev = match | frc;
    if (!pwm) begin
      unique case (com_e'(com))
        COM_TOGGLE: a.tgl = ev;
        COM_CLEAR:  a.clr = ev;
        COM_SET:    a.set = ev;
        default:    a     = '0;
      endcase
    end else begin
      unique case (com_e'(com))
        COM_CLEAR: begin
          a.clr = match;
          a.set = bottom & ~match;
        end
        COM_SET: begin
          a.set = match;
          a.clr = bottom & ~match;
        end
        default: a = '0;
      endcase
    end
    return a;
  endfunction

  // Pin data override: any nonzero field, except the reserved PWM code.
  function automatic logic occ_override(input logic pwm, input logic [COM_W-1:0] com);
    return (com != COM_OFF) && !(pwm && (com == COM_TOGGLE));
  endfunction

  function automatic logic occ_apply(input logic st, input occ_act_t a);
    if (a.tgl) return ~st;
    if (a.set) return 1'b1;
    if (a.clr) return 1'b0;
    return st;
  endfunction

endpackage

// File: rtl/occ_action_decode.sv
module occ_action_decode
  import occ_pkg::*;
(
  input  logic             pwm_mode,
  input  logic [COM_W-1:0] com,
  input  logic             match,
  input  logic             bottom,
  input  logic             frc,
  output occ_act_t         act
);
  always_comb act = occ_decode(pwm_mode, com, match, bottom, frc);
endmodule

// File: rtl/occ_state_reg.sv
module occ_state_reg
  import occ_pkg::*;
#(
  parameter logic RESET_STATE = 1'b0
) (
  input  logic     clk,
  input  logic     rst_n,
  input  occ_act_t act,
  output logic     state
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= RESET_STATE;
    else        state <= occ_apply(state, act);
  end
endmodule

// File: rtl/occ_pin_mux.sv
module occ_pin_mux
  import occ_pkg::*;
(
  input  logic             pwm_mode,
  input  logic [COM_W-1:0] com,
  input  logic             state,
  input  logic             port_data,
  input  logic             port_dir,
  output logic             override,
  output logic             pin_out,
  output logic             pin_oe
);
  always_comb begin
    override = occ_override(pwm_mode, com);
    pin_out  = override ? state : port_data;
    pin_oe   = port_dir;
  end
endmodule

// File: rtl/occ_unit.sv
module occ_unit
  import occ_pkg::*;
#(
  parameter logic RESET_STATE = 1'b0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmp_match_i,
  input  logic             cnt_bottom_i,
  input  logic             pwm_mode_i,
  input  logic [COM_W-1:0] com_i,
  input  logic             force_i,
  input  logic             port_data_i,
  input  logic             port_dir_i,
  output logic             pin_out_o,
  output logic             pin_oe_o,
  output logic             oc_state_o
);
  occ_act_t act;
  logic     act_set, act_clr, act_tgl;
  logic     override_w;
  logic     state_q;

  occ_action_decode u_dec (
    .pwm_mode (pwm_mode_i),
    .com      (com_i),
    .match    (cmp_match_i),
    .bottom   (cnt_bottom_i),
    .frc      (force_i),
    .act      (act)
  );

  // Named event wires for the checker.
  assign act_set = act.set;
  assign act_clr = act.clr;
  assign act_tgl = act.tgl;

  occ_state_reg #(.RESET_STATE(RESET_STATE)) u_st (
    .clk   (clk),
    .rst_n (rst_n),
    .act   (act),
    .state (state_q)
  );

  occ_pin_mux u_mux (
    .pwm_mode  (pwm_mode_i),
    .com       (com_i),
    .state     (state_q),
    .port_data (port_data_i),
    .port_dir  (port_dir_i),
    .override  (override_w),
    .pin_out   (pin_out_o),
    .pin_oe    (pin_oe_o)
  );

  assign oc_state_o = state_q;
endmodule

// File: rtl/occ_unit_checker.sv
module occ_unit_checker (
  input logic       clk,
  input logic       rst_n,
  input logic       cmp_match_i,
  input logic       cnt_bottom_i,
  input logic       pwm_mode_i,
  input logic [1:0] com_i,
  input logic       force_i,
  input logic       port_data_i,
  input logic       port_dir_i,
  input logic       pin_out_o,
  input logic       pin_oe_o,
  input logic       oc_state_o,
  input logic       act_set,
  input logic       act_clr,
  input logic       act_tgl,
  input logic       override_w
);
  always_comb begin
    assert_dir_passthru_R1: assert (pin_oe_o == port_dir_i);
    if (rst_n && override_w)
      assert_pin_from_state_R3: assert (pin_out_o == oc_state_o);
    if (rst_n && !override_w)
      assert_pin_from_port_R2: assert (pin_out_o == port_data_i);
  end

  assert_single_action_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({act_set, act_clr, act_tgl}));

  assert_off_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (com_i == 2'd0) |=> $stable(oc_state_o));

  assert_toggle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode_i && com_i == 2'd1 && (cmp_match_i || force_i)) |=> (oc_state_o != $past(oc_state_o)));

  assert_nonpwm_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode_i && com_i == 2'd2 && (cmp_match_i || force_i)) |=> !oc_state_o);

  assert_nonpwm_set_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_mode_i && com_i == 2'd3 && (cmp_match_i || force_i)) |=> oc_state_o);

  assert_pwm_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode_i && com_i[1] && cmp_match_i) |=> (oc_state_o == $past(com_i[0])));

  assert_pwm_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode_i && com_i[1] && cnt_bottom_i && !cmp_match_i) |=> (oc_state_o == !$past(com_i[0])));

  assert_pwm_reserved_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode_i && com_i == 2'd1) |=> $stable(oc_state_o));

  assert_pwm_force_ignored_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_mode_i && !cmp_match_i && !cnt_bottom_i) |=> $stable(oc_state_o));

  assert_idle_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!cmp_match_i && !cnt_bottom_i && !force_i) |=> $stable(oc_state_o));
endmodule

bind occ_unit occ_unit_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmp_match_i  (cmp_match_i),
  .cnt_bottom_i (cnt_bottom_i),
  .pwm_mode_i   (pwm_mode_i),
  .com_i        (com_i),
  .force_i      (force_i),
  .port_data_i  (port_data_i),
  .port_dir_i   (port_dir_i),
  .pin_out_o    (pin_out_o),
  .pin_oe_o     (pin_oe_o),
  .oc_state_o   (oc_state_o),
  .act_set      (act_set),
  .act_clr      (act_clr),
  .act_tgl      (act_tgl),
  .override_w   (override_w)
);

// File: tb/tb_occ_unit.sv
`timescale 1ns/1ps
module tb_occ_unit;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       match = 1'b0, bottom = 1'b0, pwm = 1'b0, frc = 1'b0;
  logic [1:0] com = 2'd0;
  logic       pdata = 1'b0, pdir = 1'b0;
  logic       pin_out, pin_oe, st;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2.5 clk = ~clk;

  occ_unit dut (
    .clk(clk), .rst_n(rst_n), .cmp_match_i(match), .cnt_bottom_i(bottom),
    .pwm_mode_i(pwm), .com_i(com), .force_i(frc), .port_data_i(pdata),
    .port_dir_i(pdir), .pin_out_o(pin_out), .pin_oe_o(pin_oe), .oc_state_o(st)
  );

  // Independent restatement of the requirements.
  function automatic logic exp_next(logic s, logic p, logic [1:0] c, logic m, logic b, logic f);
    if (!p) begin
      if (!(m | f)) return s;
      case (c)
        2'd1:    return !s;
        2'd2:    return 1'b0;
        2'd3:    return 1'b1;
        default: return s;
      endcase
    end
    if (c < 2'd2) return s;
    if (m) return c == 2'd3;
    if (b) return c == 2'd2;
    return s;
  endfunction

  function automatic logic exp_ovr(logic p, logic [1:0] c);
    if (c == 2'd0) return 1'b0;
    if (p && c == 2'd1) return 1'b0;
    return 1'b1;
  endfunction

  function automatic string tag_for(logic p, logic [1:0] c, logic m, logic b, logic f);
    if (c == 2'd0) return "R2";
    if (p && c == 2'd1) return "R7";
    if (p && f && !m && !b) return "R9";
    if (p) return "R6";
    if (f) return "R8";
    if (c == 2'd1) return "R4";
    return "R5";
  endfunction

  task automatic check(string tag, string what, logic actual, logic expected);
    vectors++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s %s: got %b expected %b", tag, what, actual, expected);
    end
  endtask

  task automatic idle();
    match = 1'b0; bottom = 1'b0; frc = 1'b0;
  endtask

  // Preset state using a non-PWM force (R8 path).
  task automatic preset(logic v);
    @(negedge clk);
    pwm = 1'b0; com = v ? 2'd3 : 2'd2; frc = 1'b1; match = 1'b0; bottom = 1'b0;
    @(negedge clk);
    idle();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      vectors++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state, checked while reset is held and after release
    check("R1", "state in reset", st, 1'b0);
    pdir = 1'b1;
    #0.1 check("R1", "oe follows dir", pin_oe, 1'b1);
    pdir = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    check("R1", "state after reset", st, 1'b0);
    check("R1", "oe follows dir low", pin_oe, 1'b0);

    // Exhaustive sweep: init state x mode x field x match x bottom x force
    for (int i = 0; i < 128; i++) begin
      logic s0, p, m, b, f;
      logic [1:0] c;
      logic e;
      string t;
      s0 = i[0]; p = i[1]; c = i[3:2]; m = i[4]; b = i[5]; f = i[6];
      preset(s0);
      check("R8", "preset", st, s0);
      pwm = p; com = c; match = m; bottom = b; frc = f;
      pdata = ~s0 ^ i[2]; pdir = i[3];
      @(negedge clk);
      e = exp_next(s0, p, c, m, b, f);
      t = tag_for(p, c, m, b, f);
      check(t, "state", st, e);
      check((c == 2'd0) ? "R2" : (exp_ovr(p, c) ? "R3" : "R7"), "pin_out",
            pin_out, exp_ovr(p, c) ? e : pdata);
      check("R3", "pin_oe", pin_oe, pdir);
      idle();
    end

    // R10: state survives mode changes without events
    preset(1'b1);
    @(negedge clk); pwm = 1'b1; com = 2'd2;
    repeat (3) @(negedge clk);
    check("R10", "state in PWM", st, 1'b1);
    pwm = 1'b0; com = 2'd0;
    repeat (2) @(negedge clk);
    check("R10", "state back in non-PWM", st, 1'b1);
    preset(1'b0);
    @(negedge clk); pwm = 1'b1; com = 2'd3;
    @(negedge clk); pwm = 1'b0;
    @(negedge clk);
    check("R10", "zero survives switch", st, 1'b0);

    // R11: field change takes effect with the match in the same cycle
    preset(1'b0);
    @(negedge clk); com = 2'd1; match = 1'b1;
    @(negedge clk);
    check("R11", "toggle applied", st, 1'b1);
    com = 2'd2;
    @(negedge clk);
    check("R11", "new clear applied at once", st, 1'b0);
    com = 2'd3;
    @(negedge clk);
    check("R11", "new set applied at once", st, 1'b1);
    idle();

    // R6 fast PWM waveform: set at bottom, clear at match, repeated
    preset(1'b0);
    @(negedge clk); pwm = 1'b1; com = 2'd2;
    for (int k = 0; k < 4; k++) begin
      bottom = 1'b1; @(negedge clk); bottom = 1'b0;
      check("R6", "high after bottom", st, 1'b1);
      @(negedge clk);
      match = 1'b1; @(negedge clk); match = 1'b0;
      check("R6", "low after match", st, 1'b0);
    end
    idle();

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule